// File: doc/BRIEF.md
# Dual-Compare Pulse Generator

This block is one output-compare channel. It watches an incrementing timer count that is supplied from outside and compares it against two programmed values. A match with the first value (the leading-edge value) drives the output high. A match with the second value (the trailing-edge value) drives it low. The timer, its period logic and any register access stay outside the block. The block only needs the running count and a flag that marks the last count of each timer period.

There are three modes. In continuous mode the same pulse is produced in every timer period. In single-shot mode one pulse is produced and the output then stays low until the mode leaves single-shot and comes back. When the mode is off, or the enable is low, the output is held low. Each falling edge produced by a trailing-edge match raises a one-cycle interrupt pulse. The compare values pass through shadow registers that update only at timer rollover, so rewriting them cannot corrupt a pulse that has already started.

Top module: `dual_cmp_pulse`

## Requirements
- R1: In an active mode, when the sampled count equals the leading-edge shadow value and not the trailing-edge shadow value, `oc_pin` is high from the next cycle.
- R2: In an active mode, when the sampled count equals the trailing-edge shadow value, `oc_pin` is low from the next cycle. This holds even when both shadow values are equal, so equal values never produce a pulse.
- R3: Mode `2'b10` is continuous. With a timer period of P counts, the leading value r and the trailing value f, once one full period has run with the same shadow values, `oc_pin` is high exactly in the cycles after edges whose sampled count d satisfies (d - r) mod P < (f - r) mod P.
- R4: `oc_irq` is high for exactly one cycle, in the first cycle in which `oc_pin` has fallen because of a trailing-edge match. It is never high in two consecutive cycles.
- R5: Mode `2'b01` is single-shot. After the mode enters `2'b01`, at most one pulse is produced: the first leading-edge match and then the following trailing-edge match. The pulse is (f - r) mod P cycles long. After it, the output stays low until the mode leaves `2'b01` and returns.
- R6: Modes `2'b00` and `2'b11`, and `en` low, are the off state. In the off state `oc_pin` and `oc_irq` are low from the next cycle, and the compare inputs have no effect on the outputs.
- R7: In an active mode, the shadow registers capture `cmp_rise` and `cmp_fall` only at a clock edge where `tmr_wrap` is high. In the off state they capture at every edge. A rewrite during a period leaves the rest of that period following the old values.
- R8: While `rst_n` is low, `oc_pin` and `oc_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low behaves as off |
| mode | input | 2 | 00 off, 01 single-shot, 10 continuous, 11 off |
| tmr_cnt | input | W (16) | Incrementing timer count |
| tmr_wrap | input | 1 | High while the count holds the last value of its period |
| cmp_rise | input | W (16) | Leading-edge compare value |
| cmp_fall | input | W (16) | Trailing-edge compare value |
| oc_pin | output | 1 | Compare output |
| oc_irq | output | 1 | One-cycle pulse on each falling edge from a trailing-edge match |

## Verification
A shadow register that loads at the wrong moment moves a pulse edge. That error shows on `oc_pin` inside the period in which the compare inputs were rewritten, at the first count whose old and new windows differ. A corrupted sequencer state shows as a missing or extra single-shot pulse within two timer periods. It also shows as an output that ignores the off state in the very next cycle. An interrupt that comes from the wrong condition either appears without a falling edge on `oc_pin` or goes missing one cycle after a trailing-edge match.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    OCP_OFF = 2'b00,
    OCP_ONE = 2'b01,
    OCP_RPT = 2'b10,
    OCP_RSV = 2'b11
  } ocp_mode_e;

  typedef enum logic [1:0] {
    SS_ARMED = 2'b00,
    SS_HIGH  = 2'b01,
    SS_DONE  = 2'b10
  } ss_state_e;

endpackage

// File: rtl/ocp_shadow.sv
module ocp_shadow #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [N-1:0][W-1:0] d_in,
  output logic [N-1:0][W-1:0] q_out
);

  logic [N-1:0][W-1:0] q_d;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_comb begin
      q_d[i] = q_out[i];
      if (load) q_d[i] = d_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_out[i] <= '0;
      else        q_out[i] <= q_d[i];
    end
  end

  // R7: shadow values change only after a load edge
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_out));

endmodule

// File: rtl/ocp_match.sv
module ocp_match #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic [W-1:0]        cnt,
  input  logic [N-1:0][W-1:0] refs,
  output logic [N-1:0]        hit
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    always_comb hit[i] = (cnt == refs[i]);
  end

endmodule

// File: rtl/ocp_seq.sv
module ocp_seq
  import ocp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ocp_mode_e mode_eff,
  input  logic      rise_hit,
  input  logic      fall_hit,
  output logic      pin_q,
  output logic      irq_q
);

  logic      run_rpt;
  logic      run_one;
  logic      active;
  ss_state_e ss_q;
  ss_state_e ss_d;
  logic      pin_d;
  logic      irq_d;

  always_comb begin
    run_rpt = (mode_eff == OCP_RPT);
    run_one = (mode_eff == OCP_ONE);
    active  = run_rpt | run_one;

    ss_d = ss_q;
    if (!run_one) begin
      ss_d = SS_ARMED;
    end else begin
      case (ss_q)
        SS_ARMED: if (rise_hit && !fall_hit) ss_d = SS_HIGH;
        SS_HIGH:  if (fall_hit) ss_d = SS_DONE;
        default:  ss_d = SS_DONE;
      endcase
    end

    pin_d = 1'b0;
    if (run_rpt) begin
      if (fall_hit)      pin_d = 1'b0;
      else if (rise_hit) pin_d = 1'b1;
      else               pin_d = pin_q;
    end else if (run_one) begin
      pin_d = (ss_d == SS_HIGH);
    end

    irq_d = active && fall_hit && pin_q && !pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q  <= SS_ARMED;
      pin_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ss_q  <= ss_d;
      pin_q <= pin_d;
      irq_q <= irq_d;
    end
  end

  // R6: off state forces both outputs low on the next cycle
  a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!pin_q && !irq_q));

  // R4: interrupt lasts one cycle
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R4: interrupt only accompanies a falling output
  a_r4_irq_edge: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(pin_q) && !pin_q));

  // R1: output rises only after a leading-edge match
  a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> $past(rise_hit));

  // R5: a finished single shot keeps the output low
  a_r5_done_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_q == SS_DONE) |-> !pin_q);

endmodule

// File: rtl/dual_cmp_pulse.sv
module dual_cmp_pulse
  import ocp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] tmr_cnt,
  input  logic         tmr_wrap,
  input  logic [W-1:0] cmp_rise,
  input  logic [W-1:0] cmp_fall,
  output logic         oc_pin,
  output logic         oc_irq
);

  localparam int NCMP   = 2;
  localparam int IDX_RI = 0;
  localparam int IDX_FA = 1;

  ocp_mode_e              mode_eff;
  logic                   shadow_load;
  logic [NCMP-1:0][W-1:0] cmp_in;
  logic [NCMP-1:0][W-1:0] cmp_sh;
  logic [NCMP-1:0]        hit;

  always_comb begin
    mode_eff = en ? ocp_mode_e'(mode) : OCP_OFF;
    shadow_load = tmr_wrap || !((mode_eff == OCP_ONE) || (mode_eff == OCP_RPT));
    cmp_in[IDX_RI] = cmp_rise;
    cmp_in[IDX_FA] = cmp_fall;
  end

  ocp_shadow #(.W(W), .N(NCMP)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (shadow_load),
    .d_in  (cmp_in),
    .q_out (cmp_sh)
  );

  ocp_match #(.W(W), .N(NCMP)) u_match (
    .cnt  (tmr_cnt),
    .refs (cmp_sh),
    .hit  (hit)
  );

  ocp_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_eff (mode_eff),
    .rise_hit (hit[IDX_RI]),
    .fall_hit (hit[IDX_FA]),
    .pin_q    (oc_pin),
    .irq_q    (oc_irq)
  );

endmodule

// File: tb/dual_cmp_pulse_tb.sv
module dual_cmp_pulse_tb;

  localparam int P = 10;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [1:0]  mode;
  logic [15:0] cnt;
  logic        wrap;
  logic [15:0] cmp_rise;
  logic [15:0] cmp_fall;
  logic        oc_pin;
  logic        oc_irq;

  int nchk = 0;
  int nfail = 0;
  int hi_cnt = 0;
  int irq_cnt = 0;
  int act_r = 0;
  int act_f = 0;
  int settle = P;
  bit done = 0;

  dual_cmp_pulse #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .tmr_cnt(cnt), .tmr_wrap(wrap), .cmp_rise(cmp_rise), .cmp_fall(cmp_fall),
    .oc_pin(oc_pin), .oc_irq(oc_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int d, input int r, input int f);
    return ((d - r + P) % P) < ((f - r + P) % P);
  endfunction

  task automatic step(input string tag);
    int c;
    bit ep;
    bit ei;
    string pt;
    c = int'(cnt);
    @(posedge clk);
    #1;
    cnt  = 16'((c + 1) % P);
    wrap = (cnt == 16'(P - 1));
    @(negedge clk);
    if (oc_pin) hi_cnt++;
    if (oc_irq) irq_cnt++;
    if (en && mode == 2'b10 && settle == 0) begin
      ep = in_win(c, act_r, act_f);
      ei = (c == act_f) && (act_r != act_f);
      if (act_r == act_f)  pt = "R2";
      else if (c == act_r) pt = "R1";
      else if (c == act_f) pt = "R2";
      else                 pt = tag;
      check(oc_pin == ep, pt, oc_pin, ep);
      check(oc_irq == ei, "R4", oc_irq, ei);
    end
    if (!en || mode == 2'b00 || mode == 2'b11) begin
      act_r = cmp_rise; act_f = cmp_fall; settle = P;
    end else if (c == P - 1 && (act_r != cmp_rise || act_f != cmp_fall)) begin
      act_r = cmp_rise; act_f = cmp_fall; settle = P;
    end else if (settle > 0) begin
      settle--;
    end
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic run_to(input int v);
    while (int'(cnt) != v) step("R3");
  endtask

  task automatic one_shot(input int r, input int f, input string tag);
    int len;
    mode = 2'b00;
    cmp_rise = 16'(r); cmp_fall = 16'(f);
    steps(2, tag);
    hi_cnt = 0; irq_cnt = 0;
    mode = 2'b01;
    steps(3 * P, tag);
    len = (f - r + P) % P;
    check(hi_cnt == len, "R5", hi_cnt, len);
    check(irq_cnt == (len > 0 ? 1 : 0), "R4", irq_cnt, (len > 0 ? 1 : 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; mode = 2'b00; cnt = '0; wrap = 1'b0;
    cmp_rise = '0; cmp_fall = '0;
    repeat (4) @(negedge clk);
    check(oc_pin == 1'b0, "R8", oc_pin, 0);
    check(oc_irq == 1'b0, "R8", oc_irq, 0);
    rst_n = 1'b1;
    steps(2, "R8");
    check(oc_pin == 1'b0, "R8", oc_pin, 0);

    // continuous sweep over every compare pair
    en = 1'b1; mode = 2'b10;
    for (int r = 0; r < P; r++) begin
      for (int f = 0; f < P; f++) begin
        cmp_rise = 16'(r); cmp_fall = 16'(f);
        steps(3 * P, "R3");
      end
    end

    // R7: rewrite in the middle of a pulse
    cmp_rise = 16'd2; cmp_fall = 16'd7;
    steps(3 * P, "R3");
    run_to(4);
    cmp_rise = 16'd8; cmp_fall = 16'd1;
    hi_cnt = 0;
    steps(6, "R7");
    check(hi_cnt == 3, "R7", hi_cnt, 3);
    steps(3 * P, "R7");

    // R6: enable dropped while high
    cmp_rise = 16'd0; cmp_fall = 16'd8;
    steps(3 * P, "R3");
    run_to(4);
    check(oc_pin == 1'b1, "R3", oc_pin, 1);
    en = 1'b0;
    step("R6");
    check(oc_pin == 1'b0, "R6", oc_pin, 0);

    // R6: off states ignore compare values
    en = 1'b1; mode = 2'b00; cmp_rise = 16'd1; cmp_fall = 16'd5;
    hi_cnt = 0; irq_cnt = 0;
    steps(2 * P, "R6");
    check(hi_cnt == 0 && irq_cnt == 0, "R6", hi_cnt + irq_cnt, 0);
    mode = 2'b11; cmp_rise = 16'd3; cmp_fall = 16'd9;
    hi_cnt = 0; irq_cnt = 0;
    steps(2 * P, "R6");
    check(hi_cnt == 0 && irq_cnt == 0, "R6", hi_cnt + irq_cnt, 0);
    en = 1'b0; mode = 2'b10;
    hi_cnt = 0; irq_cnt = 0;
    steps(2 * P, "R6");
    check(hi_cnt == 0 && irq_cnt == 0, "R6", hi_cnt + irq_cnt, 0);
    en = 1'b1;

    // single-shot sweep
    for (int r = 0; r < P; r++) begin
      for (int f = 0; f < P; f++) begin
        one_shot(r, f, "R5");
      end
    end

    // R5: re-arm by leaving and re-entering single-shot
    one_shot(3, 6, "R5");
    one_shot(3, 6, "R5");
    hi_cnt = 0; irq_cnt = 0;
    steps(2 * P, "R5");
    check(hi_cnt == 0, "R5", hi_cnt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule